// File: doc/BRIEF.md
# Bitstream Randomness Statistics Engine

The block takes a serial bit sequence, one bit per cycle, and collects in one pass the counts behind four classic randomness tests. It counts single bits, overlapping adjacent pairs, the patterns of non-overlapping M-bit blocks, and the lengths of maximal runs of ones (blocks) and of zeros (gaps). The sequence might be a candidate key or the output of a random generator.

The counting needs no division. Every squared sum is built up as the sequence goes by: when a counter steps from c to c+1, its square grows by 2c+1. Software reads the raw terms and forms the final chi-square values. It also makes the pass/fail decision against the thresholds. A sequence begins with a bit marked start and ends with a bit marked last. One cycle after the last bit, a done flag rises and all results are held.

Top module: `rand_stat_engine`

## Requirements
- R1: After reset, `done_o` is 0 and every count is 0. A bit accepted with `bit_start_i` high clears every count from the previous sequence and becomes the first bit of the new one.
- R2: `ones_o` and `zeros_o` count the ones and zeros of the sequence. `freq_stat_o` equals (zeros − ones)².
- R3: Pair counters count overlapping adjacent pairs. The slice index in `pair_cnt_o` is 2·previous + current (00→0, 01→1, 10→2, 11→3). The first bit forms no pair, so the four counts sum to n − 1. `pair_sq_o` is the sum of the squared pair counts. `bit_sq_o` is ones² + zeros².
- R4: The stream is cut into non-overlapping POKER_M-bit blocks. In each block the first bit is the most significant bit of the pattern index. `poker_hist_o` counts each pattern, and `poker_k_o` counts the whole blocks. Trailing bits that do not fill a block are dropped. `poker_sq_o` is the sum of the squared pattern counts.
- R5: `poker_short_o` is 1 exactly when `poker_k_o` < 5·2^POKER_M.
- R6: `block_hist_o` counts runs of ones and `gap_hist_o` counts runs of zeros. Slice i holds the runs of length i+1, for lengths 1..RUN_BINS. The run in progress when the last bit arrives is closed on that bit.
- R7: Runs longer than RUN_BINS increment `block_ovf_o` or `gap_ovf_o` according to their polarity. They touch no histogram slice.
- R8: `done_o` rises in the cycle after the last bit is accepted. All outputs then hold. Valid bits that arrive after the last bit and without a start marker are ignored until the next start.
- R9: A single bit that carries both start and last forms a sequence of length 1. It records one run of length 1 and no pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid_i | input | 1 | Input bit is valid this cycle |
| bit_start_i | input | 1 | First bit of a sequence |
| bit_last_i | input | 1 | Final bit of a sequence |
| bit_i | input | 1 | Sequence bit |
| done_o | output | 1 | Results are final |
| ones_o | output | CW | Count of ones |
| zeros_o | output | CW | Count of zeros |
| freq_stat_o | output | 2·CW | (zeros − ones)² |
| pair_cnt_o | output | 4·CW | Pair counts, slice = 2·prev+cur |
| pair_sq_o | output | 2·CW | Sum of squared pair counts |
| bit_sq_o | output | 2·CW | ones² + zeros² |
| poker_hist_o | output | 2^M·CW | Pattern counts |
| poker_k_o | output | CW | Whole blocks counted |
| poker_sq_o | output | 2·CW | Sum of squared pattern counts |
| poker_short_o | output | 1 | Too few blocks for the poker test |
| block_hist_o | output | RUN_BINS·CW | Runs of ones by length |
| gap_hist_o | output | RUN_BINS·CW | Runs of zeros by length |
| block_ovf_o | output | CW | Runs of ones longer than RUN_BINS |
| gap_ovf_o | output | CW | Runs of zeros longer than RUN_BINS |

## Verification
The tests use several kinds of input sequence:
- A strictly alternating stream puts every run in bin 1 and leaves the pairs 00 and 11 empty. It also gives a short poker count, so it separates the pair index order from the run bookkeeping.
- An all-ones stream drives a run past the last bin, which tests the overflow counter.
- A hand-made mix of long and short runs of both polarities tests the gap overflow and shows that the new start clears the results of the sequence before it.
- A long pseudo-random stream whose length is not a multiple of M fills every poker pattern and checks that the trailing bits are dropped. It also clears the short flag.

A single start-and-last bit covers the degenerate sequence. Stray valid bits sent after completion confirm that the held results do not move. Idle cycles inserted inside a sequence confirm that gaps in valid have no effect.

// File: rtl/rse_pkg.sv
package rse_pkg;
   localparam int PAIR_KINDS   = 4;
   localparam int SHORT_FACTOR = 5;
   localparam int M_MIN        = 2;
   localparam int M_MAX        = 8;
endpackage

// File: rtl/rse_bit_pairs.sv
module rse_bit_pairs
   import rse_pkg::*;
#(
   parameter int CW  = 21,
   parameter int SQW = 42
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_i,
   input  logic                     start_i,
   input  logic                     bit_i,
   output logic [CW-1:0]            ones_o,
   output logic [CW-1:0]            zeros_o,
   output logic [PAIR_KINDS*CW-1:0] pair_o,
   output logic [SQW-1:0]           pair_sq_o,
   output logic [SQW-1:0]           bit_sq_o
);
   logic            prev_q;
   logic [CW-1:0]   ones_q, zeros_q;
   logic [CW-1:0]   pair_q [PAIR_KINDS];
   logic [SQW-1:0]  pair_sq_q, bit_sq_q;
   logic [1:0]      pidx;
   logic [CW-1:0]   hit_cnt;

   assign pidx    = {prev_q, bit_i};
   assign hit_cnt = bit_i ? ones_q : zeros_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         ones_q   <= '0;
         zeros_q  <= '0;
         bit_sq_q <= '0;
      end else if (acc_i) begin
         prev_q <= bit_i;
         if (start_i) begin
            ones_q   <= CW'(bit_i);
            zeros_q  <= CW'(!bit_i);
            bit_sq_q <= SQW'(1);
         end else begin
            if (bit_i) ones_q  <= ones_q + CW'(1);
            else       zeros_q <= zeros_q + CW'(1);
            bit_sq_q <= bit_sq_q + SQW'({hit_cnt, 1'b1});
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < PAIR_KINDS; k++) pair_q[k] <= '0;
         pair_sq_q <= '0;
      end else if (acc_i) begin
         if (start_i) begin
            for (int k = 0; k < PAIR_KINDS; k++) pair_q[k] <= '0;
            pair_sq_q <= '0;
         end else begin
            pair_q[pidx] <= pair_q[pidx] + CW'(1);
            pair_sq_q    <= pair_sq_q + SQW'({pair_q[pidx], 1'b1});
         end
      end
   end

   for (genvar g = 0; g < PAIR_KINDS; g++) begin : g_pack
      assign pair_o[g*CW +: CW] = pair_q[g];
   end

   assign ones_o    = ones_q;
   assign zeros_o   = zeros_q;
   assign pair_sq_o = pair_sq_q;
   assign bit_sq_o  = bit_sq_q;
endmodule

// File: rtl/rse_poker.sv
module rse_poker
   import rse_pkg::*;
#(
   parameter int M   = 4,
   parameter int CW  = 21,
   parameter int SQW = 42,
   localparam int NPAT = 1 << M,
   localparam int PW   = $clog2(M + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_i,
   input  logic               start_i,
   input  logic               bit_i,
   output logic [NPAT*CW-1:0] hist_o,
   output logic [CW-1:0]      k_o,
   output logic [SQW-1:0]     sq_o,
   output logic               short_o
);
   if (M < M_MIN || M > M_MAX) begin : g_bad_m
      $error("rse_poker: block length out of supported range");
   end

   logic [M-1:0]   shift_q, nxt_shift;
   logic [PW-1:0]  pos_q, nxt_pos;
   logic [CW-1:0]  hist_q [NPAT];
   logic [CW-1:0]  k_q;
   logic [SQW-1:0] sq_q;
   logic           blk_done;

   assign nxt_shift = {shift_q[M-2:0], bit_i};
   assign nxt_pos   = (start_i ? PW'(0) : pos_q) + PW'(1);
   assign blk_done  = acc_i && !start_i && (nxt_pos == PW'(M));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         pos_q   <= '0;
      end else if (acc_i) begin
         shift_q <= nxt_shift;
         pos_q   <= blk_done ? PW'(0) : nxt_pos;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NPAT; b++) hist_q[b] <= '0;
         k_q  <= '0;
         sq_q <= '0;
      end else if (acc_i && start_i) begin
         for (int b = 0; b < NPAT; b++) hist_q[b] <= '0;
         k_q  <= '0;
         sq_q <= '0;
      end else if (blk_done) begin
         hist_q[nxt_shift] <= hist_q[nxt_shift] + CW'(1);
         k_q  <= k_q + CW'(1);
         sq_q <= sq_q + SQW'({hist_q[nxt_shift], 1'b1});
      end
   end

   for (genvar g = 0; g < NPAT; g++) begin : g_pack
      assign hist_o[g*CW +: CW] = hist_q[g];
   end

   assign k_o     = k_q;
   assign sq_o    = sq_q;
   assign short_o = (k_q < CW'(SHORT_FACTOR * NPAT));

   // R4
   poker_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i && !start_i) |=> (k_q == $past(k_q) || k_q == $past(k_q) + CW'(1)));
endmodule

// File: rtl/rse_run_hist.sv
module rse_run_hist #(
   parameter int BINS = 8,
   parameter int CW   = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_i,
   input  logic               start_i,
   input  logic               last_i,
   input  logic               bit_i,
   output logic [BINS*CW-1:0] gap_hist_o,
   output logic [BINS*CW-1:0] block_hist_o,
   output logic [CW-1:0]      gap_ovf_o,
   output logic [CW-1:0]      block_ovf_o
);
   if (BINS < 1) begin : g_bad_bins
      $error("rse_run_hist: at least one bin is required");
   end

   logic          cur_q;
   logic [CW-1:0] cur_len_q, run_len_next;
   logic          close_prev, close_last, fresh;
   logic [BINS*CW-1:0] hist_pk [2];
   logic [CW-1:0]      ovf_pk  [2];

   assign fresh        = start_i || (bit_i != cur_q);
   assign run_len_next = fresh ? CW'(1) : cur_len_q + CW'(1);
   assign close_prev   = acc_i && !start_i && (bit_i != cur_q);
   assign close_last   = acc_i && last_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= 1'b0;
         cur_len_q <= '0;
      end else if (acc_i) begin
         cur_q     <= bit_i;
         cur_len_q <= run_len_next;
      end
   end

   for (genvar p = 0; p < 2; p++) begin : g_pol
      logic               rec;
      logic [CW-1:0]      len;
      logic [BINS*CW-1:0] hist_q;
      logic [CW-1:0]      ovf_q;

      assign rec = (close_prev && cur_q == 1'(p)) || (close_last && bit_i == 1'(p));
      assign len = (close_last && bit_i == 1'(p)) ? run_len_next : cur_len_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_q <= '0;
            ovf_q  <= '0;
         end else if (acc_i) begin
            for (int i = 0; i < BINS; i++)
               hist_q[i*CW +: CW] <= (start_i ? CW'(0) : hist_q[i*CW +: CW])
                                     + CW'(rec && len == CW'(i + 1));
            ovf_q <= (start_i ? CW'(0) : ovf_q) + CW'(rec && len > CW'(BINS));
         end
      end

      assign hist_pk[p] = hist_q;
      assign ovf_pk[p]  = ovf_q;
   end

   assign gap_hist_o   = hist_pk[0];
   assign block_hist_o = hist_pk[1];
   assign gap_ovf_o    = ovf_pk[0];
   assign block_ovf_o  = ovf_pk[1];

   // R6
   run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_i |=> (cur_len_q != '0));
endmodule

// File: rtl/rand_stat_engine.sv
module rand_stat_engine
   import rse_pkg::*;
#(
   parameter int LEN_LOG2 = 20,
   parameter int POKER_M  = 4,
   parameter int RUN_BINS = 8,
   localparam int CW   = LEN_LOG2 + 1,
   localparam int SQW  = 2 * CW,
   localparam int NPAT = 1 << POKER_M
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bit_valid_i,
   input  logic                     bit_start_i,
   input  logic                     bit_last_i,
   input  logic                     bit_i,
   output logic                     done_o,
   output logic [CW-1:0]            ones_o,
   output logic [CW-1:0]            zeros_o,
   output logic [SQW-1:0]           freq_stat_o,
   output logic [PAIR_KINDS*CW-1:0] pair_cnt_o,
   output logic [SQW-1:0]           pair_sq_o,
   output logic [SQW-1:0]           bit_sq_o,
   output logic [NPAT*CW-1:0]       poker_hist_o,
   output logic [CW-1:0]            poker_k_o,
   output logic [SQW-1:0]           poker_sq_o,
   output logic                     poker_short_o,
   output logic [RUN_BINS*CW-1:0]   block_hist_o,
   output logic [RUN_BINS*CW-1:0]   gap_hist_o,
   output logic [CW-1:0]            block_ovf_o,
   output logic [CW-1:0]            gap_ovf_o
);
   if (LEN_LOG2 < 4 || LEN_LOG2 > 30) begin : g_bad_len
      $error("rand_stat_engine: sequence length width out of range");
   end

   logic          active_q, done_q, acc;
   logic [CW-1:0] abs_diff;

   assign acc = bit_valid_i && (bit_start_i || active_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         done_q   <= 1'b0;
      end else if (acc) begin
         active_q <= !bit_last_i;
         done_q   <= bit_last_i;
      end
   end

   rse_bit_pairs #(.CW(CW), .SQW(SQW)) u_pairs (
      .clk(clk), .rst_n(rst_n), .acc_i(acc), .start_i(bit_start_i), .bit_i(bit_i),
      .ones_o(ones_o), .zeros_o(zeros_o), .pair_o(pair_cnt_o),
      .pair_sq_o(pair_sq_o), .bit_sq_o(bit_sq_o)
   );

   rse_poker #(.M(POKER_M), .CW(CW), .SQW(SQW)) u_poker (
      .clk(clk), .rst_n(rst_n), .acc_i(acc), .start_i(bit_start_i), .bit_i(bit_i),
      .hist_o(poker_hist_o), .k_o(poker_k_o), .sq_o(poker_sq_o), .short_o(poker_short_o)
   );

   rse_run_hist #(.BINS(RUN_BINS), .CW(CW)) u_runs (
      .clk(clk), .rst_n(rst_n), .acc_i(acc), .start_i(bit_start_i),
      .last_i(bit_last_i), .bit_i(bit_i),
      .gap_hist_o(gap_hist_o), .block_hist_o(block_hist_o),
      .gap_ovf_o(gap_ovf_o), .block_ovf_o(block_ovf_o)
   );

   assign abs_diff    = (ones_o >= zeros_o) ? ones_o - zeros_o : zeros_o - ones_o;
   assign freq_stat_o = SQW'(abs_diff) * SQW'(abs_diff);
   assign done_o      = done_q;

   logic [CW+1:0] pair_total, bit_total;
   assign pair_total = (CW+2)'(pair_cnt_o[0 +: CW]) + (CW+2)'(pair_cnt_o[CW +: CW])
                     + (CW+2)'(pair_cnt_o[2*CW +: CW]) + (CW+2)'(pair_cnt_o[3*CW +: CW]);
   assign bit_total  = (CW+2)'(ones_o) + (CW+2)'(zeros_o);

   // R3
   pair_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (pair_total + (CW+2)'(1) == bit_total));

   // R4
   poker_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ((CW+6)'(poker_k_o) * (CW+6)'(POKER_M) <= (CW+6)'(bit_total)));

   // R8
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && bit_last_i) |=> done_q);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(bit_valid_i && bit_start_i)) |=>
         (done_q && $stable(ones_o) && $stable(zeros_o) && $stable(poker_k_o)
          && $stable(block_ovf_o) && $stable(gap_ovf_o)));
endmodule

// File: tb/rand_stat_engine_tb_top.sv
module rand_stat_engine_tb_top;
   localparam int CW = 21;

   typedef struct packed {
      logic [63:0] n1, n0, freq, pair_sq, bit_sq, k, poker_sq;
      logic [3:0][31:0]  pair;
      logic [15:0][31:0] pk;
      logic [7:0][31:0]  blk;
      logic [7:0][31:0]  gap;
      logic [31:0] bovf, govf, shortf;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bit_valid = 0, bit_start = 0, bit_last = 0, bit_d = 0;
   logic done_o, poker_short_o;
   logic [CW-1:0] ones_o, zeros_o, poker_k_o, block_ovf_o, gap_ovf_o;
   logic [2*CW-1:0] freq_stat_o, pair_sq_o, bit_sq_o, poker_sq_o;
   logic [4*CW-1:0] pair_cnt_o;
   logic [16*CW-1:0] poker_hist_o;
   logic [8*CW-1:0] block_hist_o, gap_hist_o;

   int checks = 0, errors = 0;
   logic seq_bits [0:1023];
   exp_t sb_q[$];
   exp_t last_exp;
   logic mon_act = 0;

   always #10 clk = ~clk;

   rand_stat_engine dut_i (
      .clk(clk), .rst_n(rst_n), .bit_valid_i(bit_valid), .bit_start_i(bit_start),
      .bit_last_i(bit_last), .bit_i(bit_d), .done_o(done_o), .ones_o(ones_o),
      .zeros_o(zeros_o), .freq_stat_o(freq_stat_o), .pair_cnt_o(pair_cnt_o),
      .pair_sq_o(pair_sq_o), .bit_sq_o(bit_sq_o), .poker_hist_o(poker_hist_o),
      .poker_k_o(poker_k_o), .poker_sq_o(poker_sq_o), .poker_short_o(poker_short_o),
      .block_hist_o(block_hist_o), .gap_hist_o(gap_hist_o),
      .block_ovf_o(block_ovf_o), .gap_ovf_o(gap_ovf_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input int n);
      exp_t e;
      int cur, len, idx, k;
      e = '0;
      for (int i = 0; i < n; i++) begin
         if (seq_bits[i]) e.n1++; else e.n0++;
         if (i > 0) e.pair[{seq_bits[i-1], seq_bits[i]}]++;
      end
      e.freq = (e.n0 - e.n1) * (e.n0 - e.n1);
      e.bit_sq = e.n0 * e.n0 + e.n1 * e.n1;
      for (int j = 0; j < 4; j++) e.pair_sq += 64'(e.pair[j]) * 64'(e.pair[j]);
      k = n / 4;
      e.k = k;
      for (int j = 0; j < k; j++) begin
         idx = 0;
         for (int b = 0; b < 4; b++) idx = idx * 2 + int'(seq_bits[j*4+b]);
         e.pk[idx]++;
      end
      for (int j = 0; j < 16; j++) e.poker_sq += 64'(e.pk[j]) * 64'(e.pk[j]);
      e.shortf = (k < 80) ? 1 : 0;
      cur = 0; len = 0;
      for (int i = 0; i <= n; i++) begin
         if (i == n || (i > 0 && int'(seq_bits[i]) != cur)) begin
            if (len > 8) begin
               if (cur == 1) e.bovf++; else e.govf++;
            end else if (cur == 1) e.blk[len-1]++;
            else e.gap[len-1]++;
            len = 0;
         end
         if (i < n) begin cur = int'(seq_bits[i]); len++; end
      end
      return e;
   endfunction

   task automatic send_seq(input int n, input int idle_every);
      sb_q.push_back(model(n));
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (idle_every > 0 && (i % idle_every) == idle_every - 1) begin
            bit_valid = 0;
            @(negedge clk);
         end
         bit_valid = 1;
         bit_start = (i == 0);
         bit_last  = (i == n - 1);
         bit_d     = seq_bits[i];
      end
      @(negedge clk);
      bit_valid = 0; bit_start = 0; bit_last = 0;
      repeat (3) @(negedge clk);
   endtask

   // Monitor: pops the scoreboard one cycle after the last bit is accepted
   always @(posedge clk) begin
      exp_t e;
      logic acc;
      #1;
      acc = bit_valid && (bit_start || mon_act);
      if (bit_valid && bit_start) mon_act = 1;
      if (acc && bit_last) begin
         mon_act = 0;
         if (sb_q.size() == 0) begin
            chk("R8 unexpected completion", 1, 0);
         end else begin
            e = sb_q.pop_front();
            last_exp = e;
            chk("R8 done", 64'(done_o), 1);
            chk("R2 ones", 64'(ones_o), e.n1);
            chk("R2 zeros", 64'(zeros_o), e.n0);
            chk("R2 freq", 64'(freq_stat_o), e.freq);
            for (int j = 0; j < 4; j++)
               chk($sformatf("R3 pair%0d", j), 64'(pair_cnt_o[j*CW +: CW]), 64'(e.pair[j]));
            chk("R3 pair_sq", 64'(pair_sq_o), e.pair_sq);
            chk("R3 bit_sq", 64'(bit_sq_o), e.bit_sq);
            for (int j = 0; j < 16; j++)
               chk($sformatf("R4 poker%0d", j), 64'(poker_hist_o[j*CW +: CW]), 64'(e.pk[j]));
            chk("R4 k", 64'(poker_k_o), e.k);
            chk("R4 poker_sq", 64'(poker_sq_o), e.poker_sq);
            chk("R5 short", 64'(poker_short_o), 64'(e.shortf));
            for (int j = 0; j < 8; j++) begin
               chk($sformatf("R6 block%0d", j + 1), 64'(block_hist_o[j*CW +: CW]), 64'(e.blk[j]));
               chk($sformatf("R6 gap%0d", j + 1), 64'(gap_hist_o[j*CW +: CW]), 64'(e.gap[j]));
            end
            chk("R7 block_ovf", 64'(block_ovf_o), 64'(e.bovf));
            chk("R7 gap_ovf", 64'(gap_ovf_o), 64'(e.govf));
         end
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 done after reset", 64'(done_o), 0);
      chk("R1 ones after reset", 64'(ones_o), 0);
      chk("R1 k after reset", 64'(poker_k_o), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // alternating stream with idle cycles (R3, R5, R6)
      for (int i = 0; i < 40; i++) seq_bits[i] = 1'(i % 2);
      send_seq(40, 3);

      // all ones: block overflow (R7)
      for (int i = 0; i < 12; i++) seq_bits[i] = 1'b1;
      send_seq(12, 0);

      // stray bits after completion are ignored (R8)
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         bit_valid = 1; bit_d = 1'(i % 2);
      end
      @(negedge clk);
      bit_valid = 0;
      @(negedge clk);
      chk("R8 hold ones", 64'(ones_o), last_exp.n1);
      chk("R8 hold zeros", 64'(zeros_o), last_exp.n0);
      chk("R8 hold ovf", 64'(block_ovf_o), 64'(last_exp.bovf));
      chk("R8 hold done", 64'(done_o), 1);

      // mixed runs with gap overflow; start clears previous results (R1, R7)
      for (int i = 0; i < 22; i++)
         seq_bits[i] = (i < 2) ? 1'b1 : (i < 12) ? 1'b0 : (i < 21) ? 1'b1 : 1'b0;
      send_seq(22, 5);

      // long pseudo-random stream, 3 trailing bits dropped (R4, R5)
      lfsr = 16'hACE1;
      for (int i = 0; i < 403; i++) begin
         seq_bits[i] = lfsr[0];
         lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      end
      send_seq(403, 7);

      // single bit with start and last together (R9)
      seq_bits[0] = 1'b1;
      send_seq(1, 0);
      chk("R9 single pair count", 64'(pair_cnt_o[3*CW +: CW]), 0);

      repeat (5) @(negedge clk);
      chk("R8 scoreboard drained", 64'(sb_q.size()), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule